// File: doc/BRIEF.md
# Back-EMF Sample-Hold Output Controller

This block sits between a digitized coil-voltage sample stream and a held output word. The analog path, converter and current-zero detector are outside it. Their results arrive as synchronous inputs: a sample word, a PWM sample strobe and a flag that is high while the coil current sits at zero. The block keeps an internal copy of the most recent sample taken inside the current-zero window. It then decides when the visible output word picks that sample up.

The decision rests on one transparency setting, which software writes through a one-bit register port. When transparency is on, the output follows every sample taken inside the window as it arrives. When transparency is off, the output stays frozen for the whole window. It loads the latest internal sample in the cycle after the current-zero flag falls. In every other case the output keeps its value.

Top module: `bemf_sh_ctrl`

## Requirements
- R1: A synchronous reset sets the output word, the internal sample and the transparency setting to zero.
- R2: The internal sample loads the data input only in a cycle where `pwm_strobe` and `izero` are both 1. A strobe while `izero` is 0 leaves it unchanged.
- R3: With transparency at 1, a strobe inside the window puts that cycle's data on `hold_out` one clock later.
- R4: With transparency at 0, `hold_out` does not change while `izero` is 1, whatever the strobe and data do.
- R5: With transparency at 0, the cycle in which `izero` goes from 1 to 0 loads the latest internal sample (not the live data) into `hold_out`, visible one clock later.
- R6: While `izero` is 0, other than at the exit edge of R5, `hold_out` holds its value and ignores data and strobe.
- R7: A write with `cfg_wr_en`=1 stores `cfg_wr_data` as the transparency setting (1 = transparent), effective from the next cycle. The write alone does not alter `hold_out`.
- R8: With transparency at 1, leaving the window does not change `hold_out`, since it already shows the last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | DATA_W | Digitized coil-voltage sample |
| pwm_strobe | input | 1 | PWM sample strobe |
| izero | input | 1 | Coil current at zero (sampling window) |
| cfg_wr_en | input | 1 | Transparency register write enable |
| cfg_wr_data | input | 1 | Transparency value to write |
| hold_out | output | DATA_W | Held sample output word |

## Verification
Every result appears exactly one clock after the cycle that causes it. A live sample (R3), an exit commit (R5) and a new transparency setting (R7) each have a single register between input and effect. The bench therefore changes inputs on the falling edge, lets one rising edge pass, and compares `hold_out` on the next falling edge. Hold requirements are checked at that same point after each stimulus cycle. The exit commit is checked against a value that was captured earlier and then overwritten on the data input, so a copy of the live data cannot pass.

// File: rtl/bemf_pkg.sv
package bemf_pkg;

    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_LIVE   = 2'd1,
        UPD_COMMIT = 2'd2
    } upd_sel_e;

    typedef struct packed {
        logic strobe;
        logic in_window;
        logic leaving;
    } win_ctl_t;

    function automatic logic take_sample(input logic strobe, input logic in_window);
        return strobe & in_window;
    endfunction

    function automatic upd_sel_e pick_update(input logic transp, input win_ctl_t c);
        if (transp && take_sample(c.strobe, c.in_window))
            return UPD_LIVE;
        if (!transp && c.leaving)
            return UPD_COMMIT;
        return UPD_HOLD;
    endfunction

endpackage

// File: rtl/bemf_cfg_reg.sv
module bemf_cfg_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_data,
    output logic transp
);
    always_ff @(posedge clk) begin
        if (rst)
            transp <= 1'b0;
        else if (wr_en)
            transp <= wr_data;
    end

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(transp)); // R7
    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> transp == $past(wr_data)); // R7
endmodule

// File: rtl/bemf_window_edge.sv
module bemf_window_edge
    import bemf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe,
    input  logic     izero,
    output win_ctl_t ctl
);
    logic izero_q;

    always_ff @(posedge clk) begin
        if (rst)
            izero_q <= 1'b0;
        else
            izero_q <= izero;
    end

    always_comb begin
        ctl.strobe    = strobe;
        ctl.in_window = izero;
        ctl.leaving   = izero_q & ~izero;
    end

    AST_EXIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ctl.leaving |=> !ctl.leaving); // R5
endmodule

// File: rtl/bemf_sample_reg.sv
module bemf_sample_reg
    import bemf_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              in_window,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] samp
);
    always_ff @(posedge clk) begin
        if (rst)
            samp <= '0;
        else if (take_sample(strobe, in_window))
            samp <= din;
    end

    AST_SAMPLE_GATED: assert property (@(posedge clk) disable iff (rst)
        !(strobe && in_window) |=> $stable(samp)); // R2
    AST_SAMPLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (strobe && in_window) |=> samp == $past(din)); // R2
endmodule

// File: rtl/bemf_out_stage.sv
module bemf_out_stage
    import bemf_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              transp,
    input  win_ctl_t          ctl,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] samp,
    output logic [DATA_W-1:0] dout
);
    upd_sel_e sel;

    always_comb sel = pick_update(transp, ctl);

    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else begin
            unique case (sel)
                UPD_LIVE:   dout <= din;
                UPD_COMMIT: dout <= samp;
                default:    dout <= dout;
            endcase
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> dout == '0); // R1
    AST_LIVE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (transp && ctl.strobe && ctl.in_window) |=> dout == $past(din)); // R3
    AST_OPAQUE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!transp && ctl.in_window) |=> $stable(dout)); // R4
    AST_EXIT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (!transp && ctl.leaving) |=> dout == $past(samp)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.in_window && !ctl.leaving) |=> $stable(dout)); // R6
    AST_TRANSP_EXIT: assert property (@(posedge clk) disable iff (rst)
        (transp && ctl.leaving) |=> $stable(dout)); // R8
endmodule

// File: rtl/bemf_sh_ctrl.sv
module bemf_sh_ctrl
    import bemf_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              pwm_strobe,
    input  logic              izero,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_data,
    output logic [DATA_W-1:0] hold_out
);
    logic              transp;
    win_ctl_t          ctl;
    logic [DATA_W-1:0] samp;

    bemf_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .transp  (transp)
    );

    bemf_window_edge u_win (
        .clk    (clk),
        .rst    (rst),
        .strobe (pwm_strobe),
        .izero  (izero),
        .ctl    (ctl)
    );

    bemf_sample_reg #(.DATA_W(DATA_W)) u_samp (
        .clk       (clk),
        .rst       (rst),
        .strobe    (ctl.strobe),
        .in_window (ctl.in_window),
        .din       (smp_data),
        .samp      (samp)
    );

    bemf_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .transp (transp),
        .ctl    (ctl),
        .din    (smp_data),
        .samp   (samp),
        .dout   (hold_out)
    );
endmodule

// File: tb/bemf_sh_ctrl_tb.sv
`timescale 1ns/1ps
module bemf_sh_ctrl_tb;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] smp_data;
    logic         pwm_strobe;
    logic         izero;
    logic         cfg_wr_en;
    logic         cfg_wr_data;
    logic [W-1:0] hold_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bemf_sh_ctrl #(.DATA_W(W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .smp_data    (smp_data),
        .pwm_strobe  (pwm_strobe),
        .izero       (izero),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .hold_out    (hold_out)
    );

    task automatic check(input string req, input logic [W-1:0] exp);
        checks++;
        if (hold_out !== exp) begin
            failures++;
            $display("FAIL %s hold_out=%h expected=%h", req, hold_out, exp);
        end
    endtask

    task automatic step(input logic s, input logic z, input logic [W-1:0] d);
        pwm_strobe = s;
        izero      = z;
        smp_data   = d;
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic v);
        pwm_strobe  = 1'b0;
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; pwm_strobe = 0; izero = 0; smp_data = '0;
        cfg_wr_en = 0; cfg_wr_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 output after reset", '0);
        // transparency reset to 0: strobe in window must not pass through
        step(1'b1, 1'b1, 12'h5A5);
        check("R1 transparency cleared", '0);
        step(1'b0, 1'b0, 12'hFFF);
        check("R5 exit commits sample", 12'h5A5);
        // a second reset: sample cleared, exit with no capture gives zero
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        step(1'b0, 1'b1, 12'h111);
        step(1'b0, 1'b0, 12'h222);
        check("R1 internal sample cleared", '0);
    endtask

    task automatic t_opaque();
        cfg_write(1'b0);
        step(1'b1, 1'b1, 12'h111);
        check("R4 hold on first strobe", '0);
        step(1'b1, 1'b1, 12'h222);
        check("R4 hold on second strobe", '0);
        step(1'b0, 1'b1, 12'h333);
        check("R4 hold without strobe", '0);
        step(1'b0, 1'b0, 12'h444);
        check("R5 commit latest sample not live data", 12'h222);
        step(1'b1, 1'b0, 12'h555);
        check("R6 hold outside window", 12'h222);
    endtask

    task automatic t_transp();
        cfg_write(1'b1);
        check("R7 write keeps output", 12'h222);
        step(1'b1, 1'b1, 12'h0A1);
        check("R3 live sample one", 12'h0A1);
        step(1'b0, 1'b1, 12'h0B2);
        check("R3 no strobe no update", 12'h0A1);
        step(1'b1, 1'b1, 12'h0C3);
        check("R3 live sample two", 12'h0C3);
        step(1'b0, 1'b0, 12'h7FF);
        check("R8 exit with transparency unchanged", 12'h0C3);
        step(1'b0, 1'b0, 12'h6EE);
        check("R6 idle hold", 12'h0C3);
    endtask

    task automatic t_gate();
        cfg_write(1'b0);
        step(1'b1, 1'b0, 12'h3AA);
        check("R6 strobe outside window ignored", 12'h0C3);
        step(1'b0, 1'b1, 12'h111);
        step(1'b0, 1'b0, 12'h999);
        check("R2 outside strobe not captured", 12'h0C3);
    endtask

    task automatic t_switch();
        step(1'b1, 1'b1, 12'h123);
        check("R4 opaque window", 12'h0C3);
        cfg_write(1'b1);
        check("R7 switch mid window keeps value", 12'h0C3);
        step(1'b1, 1'b1, 12'h456);
        check("R7 transparent after write", 12'h456);
        cfg_write(1'b0);
        check("R7 switch back keeps value", 12'h456);
        step(1'b1, 1'b1, 12'h789);
        check("R4 opaque again", 12'h456);
        step(1'b0, 1'b0, 12'hABC);
        check("R5 commit after switch", 12'h789);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_opaque();
        t_transp();
        t_gate();
        t_switch();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule